// File: doc/BRIEF.md
# Iterative AES Block Cipher Core

This core encrypts or decrypts a single 128-bit block under a 128-, 192- or 256-bit key using the standard AES round functions. It performs one full round per clock. Key words and data words arrive over one word-wide write channel with valid/ready flow control. A single start pulse launches the operation. The result appears on a 128-bit output, read as four 32-bit words, and a done flag marks it valid.

Each key word write restarts the key schedule. The schedule expands the whole key into an internal round-key store, one 32-bit word per cycle, so that decryption can read the round keys from last to first. The key schedule runs in the background. Data words may be written while it runs, but a start is held off until the schedule is complete. Once a start is accepted, the latency depends only on the key length.

Flow-control rules for the write channel are as follows. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole cipher run, from the edge that accepts a start until the result is registered. A word offered while `wr_ready` is low is not taken. `wr_ready` stays high while the key schedule is expanding.

Top module: `aes_iter_core`

## Requirements
- R1: Encryption gives the standard AES ciphertext for each key length. `key_len` selects the length: 2'b00 for 128 bits with 4 key words, 2'b01 for 192 bits with 6 key words, and 2'b10 or 2'b11 for 256 bits with 8 key words. `key_len` is sampled with every key word write.
- R2: With `decrypt` high at start, the core applies the inverse rounds with the round keys in reverse order, and so recovers the plaintext from the ciphertext.
- R3: `done` rises exactly Nr+2 clock edges after the edge that accepts a start: 12, 14 or 16 edges for 128-, 192- or 256-bit keys.
- R4: Write addresses 0 to 7 select key words 0 to 7. Addresses 8 to 11 select data words 0 to 3. Addresses 12 to 15 are taken but have no effect. Word 0 of every 128- or 256-bit value is its most significant 32 bits, and `dout[127:96]` is output word 0.
- R5: A start is ignored, and leaves `done` and `dout` unchanged, in any of these cases: the core is running, the key schedule is expanding, no key has yet been written, or a key word is taken in the same cycle.
- R6: The edge that accepts a start clears `done`. Once set, `done` stays high and `dout` stays stable until the next accepted start.
- R7: `wr_ready` is low while a cipher run is in progress. A word offered during a run is not stored.
- R8: A key word write makes `busy` high for the key expansion, which takes 40, 46 or 52 cycles. Data words written during the expansion are stored.
- R9: With a 128-bit key, key words 4 to 7 have no effect on the result. With a 192-bit key, words 6 and 7 have no effect.
- R10: After reset, `done` is 0, `busy` is 0, `wr_ready` is 1 and `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_len | input | 2 | Key length code, sampled on each key word write |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Core can take a write word |
| wr_addr | input | 4 | Word address (key 0-7, data 8-11) |
| wr_data | input | 32 | Write word |
| decrypt | input | 1 | Direction, sampled with an accepted start |
| start | input | 1 | Launch request pulse |
| busy | output | 1 | Cipher run or key expansion in progress |
| done | output | 1 | Result on `dout` is valid |
| dout | output | 128 | Result block, word 0 in bits 127:96 |

## Verification
The bound checker watches four properties on every cycle. It counts the exact latency from an accepted start to the rise of `done`. It checks that `done` is cleared on acceptance and stays low through the run. It checks that `dout` holds still while `done` is up. It checks that no start is taken while busy and that the write channel closes once a run begins. Correct cipher values in both directions cannot be shown by these properties, nor can word ordering, the silence of unused key words, or data writes landing during expansion. Those rest on the bench's known-answer table and its directed scenarios.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;
  localparam int WORD_W   = 32;
  localparam int BLK_W    = 128;
  localparam int COLS     = BLK_W / WORD_W;
  localparam int MAX_NK   = 8;
  localparam int MAX_NR   = MAX_NK + 6;
  localparam int RK_WORDS = COLS * (MAX_NR + 1);
  localparam int RK_IDX_W = $clog2(RK_WORDS);
  localparam int RND_W    = $clog2(MAX_NR + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_OUT} phase_t;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254, zero maps to zero
  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] p;
    logic [7:0] r;
    p = a;
    r = 8'h01;
    for (int k = 1; k < 8; k++) begin
      p = gmul(p, p);
      r = gmul(r, p);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
    logic [15:0] t;
    t = {b, b} << n;
    return t[15:8];
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] i;
    i = ginv(a);
    return i ^ rotl8(i, 1) ^ rotl8(i, 2) ^ rotl8(i, 3) ^ rotl8(i, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] a);
    return ginv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [31:0] mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
            a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
            a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
            xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)};
  endfunction

  function automatic logic [31:0] inv_mix_col(input logic [31:0] c);
    logic [7:0] a0, a1, a2, a3;
    {a0, a1, a2, a3} = c;
    return {gmul(a0, 8'h0e) ^ gmul(a1, 8'h0b) ^ gmul(a2, 8'h0d) ^ gmul(a3, 8'h09),
            gmul(a0, 8'h09) ^ gmul(a1, 8'h0e) ^ gmul(a2, 8'h0b) ^ gmul(a3, 8'h0d),
            gmul(a0, 8'h0d) ^ gmul(a1, 8'h09) ^ gmul(a2, 8'h0e) ^ gmul(a3, 8'h0b),
            gmul(a0, 8'h0b) ^ gmul(a1, 8'h0d) ^ gmul(a2, 8'h09) ^ gmul(a3, 8'h0e)};
  endfunction

  function automatic logic [3:0] nk_of(input logic [1:0] code);
    return (code == 2'b00) ? 4'd4 : ((code == 2'b01) ? 4'd6 : 4'd8);
  endfunction
endpackage

// File: rtl/aes_iter_keysched.sv
module aes_iter_keysched
  import aes_iter_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                kw_en,
  input  logic [2:0]          kw_idx,
  input  logic [WORD_W-1:0]   kw_data,
  input  logic [1:0]          klen_in,
  input  logic [RND_W-1:0]    rd_rnd,
  output logic [BLK_W-1:0]    rk_out,
  output logic                sched_ok,
  output logic                expanding,
  output logic [RND_W-1:0]    nr_out
);
  logic [WORD_W-1:0]   mem [RK_WORDS];
  logic [1:0]          klen_q;
  logic [RK_IDX_W-1:0] wi;
  logic [2:0]          pos;
  logic [7:0]          rcon;
  logic                run, ok;
  logic [3:0]          nk_c;
  logic [RND_W-1:0]    nr_c;
  logic [RK_IDX_W-1:0] last_w;
  logic [RK_IDX_W-1:0] rd_base;
  logic [WORD_W-1:0]   prev, old, temp;

  assign nk_c   = nk_of(klen_q);
  assign nr_c   = RND_W'(nk_c) + RND_W'(6);
  assign last_w = {nr_c + RND_W'(1), 2'b00} - RK_IDX_W'(1);

  always_comb begin
    prev = mem[wi - RK_IDX_W'(1)];
    old  = mem[wi - RK_IDX_W'(nk_c)];
    if (pos == 3'd0)
      temp = sub_word({prev[23:0], prev[31:24]}) ^ {rcon, 24'h0};
    else if (nk_c == 4'd8 && pos == 3'd4)
      temp = sub_word(prev);
    else
      temp = prev;
  end

  // round-key store: key words land at the bottom, expansion fills the rest
  always_ff @(posedge clk) begin
    if (kw_en)    mem[RK_IDX_W'(kw_idx)] <= kw_data;
    else if (run) mem[wi] <= old ^ temp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      klen_q <= 2'b00;
      wi     <= '0;
      pos    <= '0;
      rcon   <= 8'h01;
      run    <= 1'b0;
      ok     <= 1'b0;
    end else if (kw_en) begin
      klen_q <= klen_in;
      wi     <= RK_IDX_W'(nk_of(klen_in));
      pos    <= '0;
      rcon   <= 8'h01;
      run    <= 1'b1;
      ok     <= 1'b0;
    end else if (run) begin
      wi  <= wi + RK_IDX_W'(1);
      pos <= (pos == 3'(nk_c - 4'd1)) ? 3'd0 : pos + 3'd1;
      if (pos == 3'd0) rcon <= xtime(rcon);
      if (wi == last_w) begin
        run <= 1'b0;
        ok  <= 1'b1;
      end
    end
  end

  assign rd_base = RK_IDX_W'({rd_rnd, 2'b00});
  for (genvar w = 0; w < COLS; w++) begin : g_rk
    assign rk_out[BLK_W-1-WORD_W*w -: WORD_W] = mem[rd_base + RK_IDX_W'(w)];
  end

  assign sched_ok  = ok;
  assign expanding = run;
  assign nr_out    = nr_c;
endmodule

// File: rtl/aes_iter_round.sv
module aes_iter_round
  import aes_iter_pkg::*;
(
  input  logic [BLK_W-1:0] st,
  input  logic [BLK_W-1:0] rk,
  input  logic             dec,
  input  logic             last,
  output logic [BLK_W-1:0] nxt
);
  logic [BLK_W-1:0] subv, ark, mixv, imixv;

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < 4; r++) begin : g_row
      localparam int FWD = r + 4 * ((c + r) % 4);
      localparam int BWD = r + 4 * ((c - r + 4) % 4);
      logic [7:0] moved;
      assign moved = dec ? st[BLK_W-1-8*BWD -: 8] : st[BLK_W-1-8*FWD -: 8];
      assign subv[BLK_W-1-8*(4*c+r) -: 8] = dec ? inv_sbox(moved) : sbox(moved);
    end
    assign mixv[BLK_W-1-WORD_W*c -: WORD_W]  = mix_col(subv[BLK_W-1-WORD_W*c -: WORD_W]);
    assign imixv[BLK_W-1-WORD_W*c -: WORD_W] = inv_mix_col(ark[BLK_W-1-WORD_W*c -: WORD_W]);
  end

  assign ark = subv ^ rk;
  assign nxt = dec ? (last ? ark : imixv) : ((last ? subv : mixv) ^ rk);
endmodule

// File: rtl/aes_iter_core.sv
module aes_iter_core
  import aes_iter_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   key_len,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [3:0]   wr_addr,
  input  logic [31:0]  wr_data,
  input  logic         decrypt,
  input  logic         start,
  output logic         busy,
  output logic         done,
  output logic [127:0] dout
);
  phase_t           phase;
  logic [RND_W-1:0] rnd, nr, rd_rnd;
  logic             dec_q;
  logic [BLK_W-1:0] st_q, din_q, rk, nxt;
  logic             wr_fire, key_wr, dat_wr;
  logic             sched_ok, expanding, running, run_go;

  assign running  = (phase != PH_IDLE);
  assign wr_ready = !running;
  assign wr_fire  = wr_valid && wr_ready;
  assign key_wr   = wr_fire && !wr_addr[3];
  assign dat_wr   = wr_fire && (wr_addr[3:2] == 2'b10);
  assign busy     = running || expanding;
  assign run_go   = start && !running && sched_ok && !key_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else
      for (int w = 0; w < COLS; w++)
        if (dat_wr && wr_addr[1:0] == 2'(w)) din_q[BLK_W-1-WORD_W*w -: WORD_W] <= wr_data;
  end

  aes_iter_keysched u_ks (
    .clk(clk), .rst_n(rst_n), .kw_en(key_wr), .kw_idx(wr_addr[2:0]),
    .kw_data(wr_data), .klen_in(key_len), .rd_rnd(rd_rnd), .rk_out(rk),
    .sched_ok(sched_ok), .expanding(expanding), .nr_out(nr)
  );

  assign rd_rnd = (phase == PH_LOAD) ? (dec_q ? nr : '0) : (dec_q ? nr - rnd : rnd);

  aes_iter_round u_rnd (
    .st(st_q), .rk(rk), .dec(dec_q), .last(rnd == nr), .nxt(nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      rnd   <= '0;
      dec_q <= 1'b0;
      st_q  <= '0;
      dout  <= '0;
      done  <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: if (run_go) begin
          dec_q <= decrypt;
          done  <= 1'b0;
          phase <= PH_LOAD;
        end
        PH_LOAD: begin
          st_q  <= din_q ^ rk;
          rnd   <= RND_W'(1);
          phase <= PH_ROUND;
        end
        PH_ROUND: begin
          st_q <= nxt;
          if (rnd == nr) phase <= PH_OUT;
          else           rnd   <= rnd + RND_W'(1);
        end
        default: begin
          dout  <= st_q;
          done  <= 1'b1;
          phase <= PH_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/aes_iter_core_chk.sv
module aes_iter_core_chk
  import aes_iter_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             wr_ready,
  input logic [127:0]     dout,
  input logic             run_go,
  input logic             running,
  input logic [RND_W-1:0] nr
);
  logic [RND_W:0] lat_cnt;
  logic           counting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cnt  <= '0;
      counting <= 1'b0;
    end else if (run_go) begin
      lat_cnt  <= '0;
      counting <= 1'b1;
    end else if (counting) begin
      lat_cnt <= lat_cnt + 1'b1;
      if (done) counting <= 1'b0;
    end
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (lat_cnt == ({1'b0, nr} + (RND_W+1)'(2))));

  assert_no_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !running |-> !run_go);

  assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_go |=> !done);

  assert_done_low_in_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> !done);

  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(dout));

  assert_write_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    run_go |=> !wr_ready);
endmodule

bind aes_iter_core aes_iter_core_chk u_chk (.*);

// File: tb/aes_iter_core_tb.sv
`timescale 1ns/1ps
module aes_iter_core_tb;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic [1:0]   key_len = 2'b00;
  logic         wr_valid = 1'b0, decrypt = 1'b0, start = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [31:0]  wr_data = '0;
  logic         wr_ready, busy, done;
  logic [127:0] dout;

  always #2 clk = ~clk;

  aes_iter_core u_dut (
    .clk(clk), .rst_n(rst_n), .key_len(key_len), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .decrypt(decrypt), .start(start), .busy(busy), .done(done), .dout(dout)
  );

  localparam logic [255:0] KA = {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0};
  localparam logic [127:0] PA = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CA = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [255:0] K1 = {128'h000102030405060708090a0b0c0d0e0f, 128'h0};
  localparam logic [255:0] K2 = {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0};
  localparam logic [255:0] K3 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [127:0] PT = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C1 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] C2 = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
  localparam logic [127:0] C3 = 128'h8ea2b7ca516745bfeafc49904b496089;

  typedef struct packed {
    logic [1:0]   kl;
    logic         dec;
    logic [255:0] key;
    logic [127:0] din;
    logic [127:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    {2'd0, 1'b0, KA, PA, CA}, {2'd0, 1'b1, KA, CA, PA},
    {2'd0, 1'b0, K1, PT, C1}, {2'd0, 1'b1, K1, C1, PT},
    {2'd1, 1'b0, K2, PT, C2}, {2'd1, 1'b1, K2, C2, PT},
    {2'd2, 1'b0, K3, PT, C3}, {2'd2, 1'b1, K3, C3, PT}
  };

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nr_of(input logic [1:0] kl);
    return (kl == 2'd0) ? 10 : ((kl == 2'd1) ? 12 : 14);
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic put_key(input logic [1:0] kl, input logic [255:0] k);
    key_len = kl;
    for (int i = 0; i < nr_of(kl) - 6; i++) wr(4'(i), k[255-32*i -: 32]);
  endtask

  task automatic put_data(input logic [127:0] d);
    for (int i = 0; i < 4; i++) wr(4'(8 + i), d[127-32*i -: 32]);
  endtask

  task automatic wait_sched();
    int g = 0;
    while (busy && g < 200) begin @(posedge clk); #1; g++; end
  endtask

  task automatic launch(input logic d, output int cyc);
    decrypt = d; start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(!done, "R6 done cleared by accepted start", {127'b0, done}, 128'd0);
    cyc = 0;
    while (!done && cyc < 64) begin @(posedge clk); #1; cyc++; end
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset state
    chk(!done && !busy && wr_ready && dout == '0, "R10 reset outputs",
        {busy, wr_ready, done, dout[124:0]}, {3'b010, 125'd0});

    // R5 start with no key written is ignored
    start = 1'b1; @(posedge clk); #1; start = 1'b0;
    repeat (20) @(posedge clk); #1;
    chk(!done && !busy, "R5 start before key ignored", {126'b0, busy, done}, 128'd0);

    // known-answer table
    for (int v = 0; v < 8; v++) begin
      put_key(VECS[v].kl, VECS[v].key);
      chk(busy && wr_ready, $sformatf("R8 expanding after key, vec %0d", v),
          {126'b0, busy, wr_ready}, 128'd3);
      wait_sched();
      put_data(VECS[v].din);
      launch(VECS[v].dec, cyc);
      chk(cyc == nr_of(VECS[v].kl) + 2, $sformatf("R3 latency vec %0d", v),
          128'(cyc), 128'(nr_of(VECS[v].kl) + 2));
      chk(dout == VECS[v].exp,
          $sformatf("%s R4 result vec %0d", VECS[v].dec ? "R2" : "R1", v), dout, VECS[v].exp);
    end

    // R8 data written while key expansion runs
    put_key(2'd0, KA);
    chk(busy, "R8 busy during expansion", {127'b0, busy}, 128'd1);
    put_data(PA);
    wait_sched();
    launch(1'b0, cyc);
    chk(dout == CA, "R8 data taken during expansion", dout, CA);

    // R6 result held while idle
    repeat (10) @(posedge clk); #1;
    chk(done && dout == CA, "R6 result held", dout, CA);

    // R5 start during expansion ignored
    wr(4'd0, KA[255:224]);
    start = 1'b1; @(posedge clk); #1; start = 1'b0;
    repeat (5) @(posedge clk); #1;
    chk(done && busy, "R5 start during expansion ignored", {126'b0, busy, done}, 128'd3);
    wait_sched();
    chk(done && dout == CA, "R5 output untouched after expansion", dout, CA);

    // R5 start while running, R7 write offered while running
    decrypt = 1'b0; start = 1'b1; @(posedge clk); #1; start = 1'b0;
    repeat (2) @(posedge clk); #1;
    chk(!wr_ready, "R7 write channel closed in run", {127'b0, wr_ready}, 128'd0);
    start = 1'b1; wr_valid = 1'b1; wr_addr = 4'd8; wr_data = 32'hdeadbeef;
    @(posedge clk); #1;
    start = 1'b0; wr_valid = 1'b0;
    cyc = 3;
    while (!done && cyc < 64) begin @(posedge clk); #1; cyc++; end
    chk(cyc == 12, "R5 latency unaffected by extra start", 128'(cyc), 128'd12);
    repeat (20) @(posedge clk); #1;
    chk(done && dout == CA, "R5 no second run launched", dout, CA);
    launch(1'b0, cyc);
    chk(dout == CA, "R7 blocked write not stored", dout, CA);

    // R9 unused key words
    put_key(2'd0, K1);
    for (int i = 4; i < 8; i++) wr(4'(i), 32'hA5A5_0000 + 32'(i));
    wait_sched();
    put_data(PT);
    launch(1'b0, cyc);
    chk(dout == C1, "R9 128-bit key ignores words 4-7", dout, C1);
    put_key(2'd1, K2);
    wr(4'd6, 32'h1234_5678); wr(4'd7, 32'h9abc_def0);
    wait_sched();
    launch(1'b0, cyc);
    chk(dout == C2, "R9 192-bit key ignores words 6-7", dout, C2);

    // R4 data-address alias 12-15 has no effect
    wr(4'd12, 32'hffff_ffff); wr(4'd15, 32'h0);
    launch(1'b0, cyc);
    chk(dout == C2, "R4 addresses 12-15 ignored", dout, C2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule